// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block guards a shared medium against a station whose transmitter will not stop. It runs from a 10 MHz time base and measures how long transmit activity lasts without a break. When a burst runs past the jabber limit, the block takes away the driver enable. It then holds the driver off until the transmit input has been quiet and the driver has been fault-free for the long unjab interval. For the whole time the driver is locked off, the block raises a request for a collision/SQE message toward the host.

Two outside conditions also force the driver off and raise the SQE request for as long as they last. One is an external disable, which signals that the driver supply has been removed. The other is a low supply. Neither of them changes the timing state. A fault sensed on the driver output behaves differently: it locks the driver immediately, and any fault that appears during the unjab interval restarts that interval. Both limits are parameters counted in clock cycles, so a test can shrink them.

Top module: `jabber_guard`

## Requirements
- R1: After JAB_CYCLES consecutive clock edges with tx_active high, the block locks. From that edge onward, drv_en is 0 and jab_sqe is 1.
- R2: A burst of JAB_CYCLES-1 edges does not lock the block. A single idle edge clears the burst count, so two such bursts separated by one idle edge leave drv_en at 1 and jab_sqe at 0.
- R3: Once locked, jab_sqe stays 1 and drv_en stays 0 until UNJAB_CYCLES consecutive edges have tx_active and drv_fault both low. On that last edge, drv_en returns to 1 and jab_sqe returns to 0.
- R4: While locked, a single edge with tx_active or drv_fault high restarts the unjab count from zero.
- R5: When drv_fault is high on an edge in the unlocked state, the block locks on that same edge. The outputs then show drv_en 0 and jab_sqe 1, and release follows R3.
- R6: While ext_off is high, drv_en is 0 and jab_sqe is 1. ext_off leaves both the burst count and the lock state unchanged.
- R7: While supply_ok is low, drv_en is 0 and jab_sqe is 1. supply_ok leaves the timing state unchanged.
- R8: While rst is high, both outputs read 0 and the block is unlocked. The first edge after reset with quiet inputs and supply_ok high sets drv_en to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz time-base clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_active | input | 1 | Transmit data is present on the host side |
| drv_fault | input | 1 | A fault has been sensed on the driver output |
| ext_off | input | 1 | External disable (driver supply removed) |
| supply_ok | input | 1 | Supply is above the minimum operating level |
| drv_en | output | 1 | Registered permission for the medium driver |
| jab_sqe | output | 1 | Registered request for the collision/SQE message |

## Verification
Several functions can act on the same clock edge. In one case, the final edge of an over-long burst arrives while ext_off is high. This confirms that the forced disable did not stop the burst count, and that the lock remains after ext_off drops. In another case, an active or faulty edge lands at every position of the unjab interval, including its last one, so a restart collides with a release that was about to happen. In each case the bench predicts the exact release edge from the two limits and samples drv_en on the edges just before and just after it.

// File: rtl/jg_pkg.sv
`timescale 1ns/1ps
package jg_pkg;

  typedef enum logic {
    MODE_OPEN   = 1'b0,
    MODE_LOCKED = 1'b1
  } guard_mode_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/jg_span_timer.sv
`timescale 1ns/1ps
module jg_span_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  import jg_pkg::*;

  localparam int unsigned W = cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  // hit marks the edge that completes LIMIT consecutive increments
  assign hit = inc && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (hit) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/jg_ctrl.sv
`timescale 1ns/1ps
module jg_ctrl (
  input  logic               clk,
  input  logic               rst,
  input  logic               tx_active,
  input  logic               drv_fault,
  input  logic               ext_off,
  input  logic               supply_ok,
  input  logic               jab_hit,
  input  logic               unjab_hit,
  output jg_pkg::guard_mode_e mode,
  output logic               drv_en,
  output logic               jab_sqe
);
  import jg_pkg::*;

  guard_mode_e mode_q, mode_d;
  logic        forced_off;

  assign forced_off = ext_off || !supply_ok;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_OPEN:   if (jab_hit || drv_fault) mode_d = MODE_LOCKED;
      MODE_LOCKED: if (unjab_hit && !tx_active && !drv_fault) mode_d = MODE_OPEN;
      default:     mode_d = MODE_OPEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_OPEN;
      drv_en  <= 1'b0;
      jab_sqe <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      drv_en  <= (mode_d == MODE_OPEN) && !drv_fault && !forced_off;
      jab_sqe <= (mode_d == MODE_LOCKED) || forced_off;
    end
  end

  assign mode = mode_q;

endmodule

// File: rtl/jabber_guard.sv
`timescale 1ns/1ps
module jabber_guard #(
  parameter int unsigned JAB_CYCLES   = 260000,
  parameter int unsigned UNJAB_CYCLES = 4000000
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_active,
  input  logic drv_fault,
  input  logic ext_off,
  input  logic supply_ok,
  output logic drv_en,
  output logic jab_sqe
);
  import jg_pkg::*;

  guard_mode_e mode;
  logic        locked;
  logic        jab_clr, jab_inc, jab_hit;
  logic        unj_clr, unj_inc, unj_hit;

  assign locked  = (mode == MODE_LOCKED);

  // burst timer: runs only while open and active, cleared by any idle edge
  assign jab_inc = tx_active && !locked;
  assign jab_clr = !jab_inc;

  // quiet timer: runs only while locked with no activity and no fault
  assign unj_inc = locked && !tx_active && !drv_fault;
  assign unj_clr = !unj_inc;

  jg_span_timer #(.LIMIT(JAB_CYCLES)) u_burst (
    .clk (clk),
    .rst (rst),
    .clr (jab_clr),
    .inc (jab_inc),
    .hit (jab_hit)
  );

  jg_span_timer #(.LIMIT(UNJAB_CYCLES)) u_quiet (
    .clk (clk),
    .rst (rst),
    .clr (unj_clr),
    .inc (unj_inc),
    .hit (unj_hit)
  );

  jg_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tx_active (tx_active),
    .drv_fault (drv_fault),
    .ext_off   (ext_off),
    .supply_ok (supply_ok),
    .jab_hit   (jab_hit),
    .unjab_hit (unj_hit),
    .mode      (mode),
    .drv_en    (drv_en),
    .jab_sqe   (jab_sqe)
  );

endmodule

// File: rtl/jabber_guard_chk.sv
`timescale 1ns/1ps
module jabber_guard_chk #(
  parameter int unsigned JAB_CYCLES = 260000
) (
  input logic clk,
  input logic rst,
  input logic tx_active,
  input logic drv_fault,
  input logic ext_off,
  input logic supply_ok,
  input logic drv_en,
  input logic jab_sqe
);
  localparam int unsigned RW = $clog2(JAB_CYCLES + 2);
  localparam logic [RW-1:0] RMAX = RW'(JAB_CYCLES + 1);
  localparam logic [RW-1:0] RLIM = RW'(JAB_CYCLES);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !tx_active) run_q <= '0;
    else if (run_q != RMAX) run_q <= run_q + 1'b1;
  end

  AST_LONG_BURST_OFF: assert property (@(posedge clk) disable iff (rst)
    (run_q >= RLIM) |-> !drv_en); // R1
  AST_SQE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    jab_sqe |-> !drv_en); // R3
  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    drv_fault |=> (!drv_en && jab_sqe)); // R5
  AST_EXT_FORCES: assert property (@(posedge clk) disable iff (rst)
    ext_off |=> (!drv_en && jab_sqe)); // R6
  AST_SUPPLY_FORCES: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (!drv_en && jab_sqe)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!drv_en && !jab_sqe)); // R8

endmodule

bind jabber_guard jabber_guard_chk #(.JAB_CYCLES(JAB_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tx_active (tx_active),
  .drv_fault (drv_fault),
  .ext_off   (ext_off),
  .supply_ok (supply_ok),
  .drv_en    (drv_en),
  .jab_sqe   (jab_sqe)
);

// File: tb/jabber_guard_test.sv
`timescale 1ns/1ps
module jabber_guard_test;
  localparam int J = 8;
  localparam int U = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx = 1'b0, flt = 1'b0, ext = 1'b0, sup = 1'b1;
  logic drv_en, jab_sqe;
  int   total = 0;
  int   bad = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  jabber_guard #(.JAB_CYCLES(J), .UNJAB_CYCLES(U)) uut (
    .clk(clk), .rst(rst), .tx_active(tx), .drv_fault(flt),
    .ext_off(ext), .supply_ok(sup), .drv_en(drv_en), .jab_sqe(jab_sqe)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic e_en, input logic e_sqe);
    total++;
    if (drv_en !== e_en || jab_sqe !== e_sqe) begin
      bad++;
      $display("FAIL %s: drv_en=%b jab_sqe=%b expected drv_en=%b jab_sqe=%b",
               req, drv_en, jab_sqe, e_en, e_sqe);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tx = 1'b0; flt = 1'b0; ext = 1'b0; sup = 1'b1;
    tick(); tick();
    chk("R8 reset", 1'b0, 1'b0);
    rst = 1'b0;
    tick();
    chk("R8 first edge", 1'b1, 1'b0);
  endtask

  // locked state expected; verifies release after exactly U quiet edges
  task automatic expect_release(input string req);
    repeat (U - 1) tick();
    chk({req, " before release"}, 1'b0, 1'b1);
    tick();
    chk({req, " at release"}, 1'b1, 1'b0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    // R1 / R2: burst length sweep
    for (int n = 1; n <= J + 3; n++) begin
      do_reset();
      tx = 1'b1;
      repeat (n) tick();
      if (n >= J) begin
        chk("R1 burst trip", 1'b0, 1'b1);
        tx = 1'b0;
        expect_release("R3 after burst");
      end else begin
        chk("R2 short burst", 1'b1, 1'b0);
        tx = 1'b0;
        tick();
        chk("R2 idle after burst", 1'b1, 1'b0);
      end
    end

    // R2: one idle edge clears the count
    do_reset();
    tx = 1'b1; repeat (J - 1) tick();
    tx = 1'b0; tick();
    tx = 1'b1; repeat (J - 1) tick();
    chk("R2 count cleared by gap", 1'b1, 1'b0);
    tick();
    chk("R1 full burst after gap", 1'b0, 1'b1);
    tx = 1'b0;
    expect_release("R3 after gap burst");

    // R4: disturb at every position of the quiet interval
    for (int kind = 0; kind < 2; kind++) begin
      for (int p = 0; p < U; p++) begin
        do_reset();
        tx = 1'b1; repeat (J) tick();
        tx = 1'b0;
        repeat (p) tick();
        chk("R4 still locked", 1'b0, 1'b1);
        if (kind == 0) tx = 1'b1; else flt = 1'b1;
        tick();
        tx = 1'b0; flt = 1'b0;
        chk("R4 disturbed", 1'b0, 1'b1);
        expect_release("R4 restart");
      end
    end

    // R5: fault while open
    do_reset();
    flt = 1'b1; tick();
    chk("R5 fault locks", 1'b0, 1'b1);
    flt = 1'b0;
    expect_release("R5 recovery");

    // R5 and burst end on the same edge
    do_reset();
    tx = 1'b1; repeat (J - 1) tick();
    flt = 1'b1; tick();
    chk("R5 fault with trip", 1'b0, 1'b1);
    tx = 1'b0; flt = 1'b0;
    expect_release("R5 joint recovery");

    // R6: external disable while open
    do_reset();
    ext = 1'b1; repeat (3) tick();
    chk("R6 forced", 1'b0, 1'b1);
    ext = 1'b0; tick();
    chk("R6 removed", 1'b1, 1'b0);

    // R6: burst count keeps running under ext_off
    do_reset();
    tx = 1'b1; repeat (J - 1) tick();
    ext = 1'b1; tick();
    chk("R6 forced at trip edge", 1'b0, 1'b1);
    ext = 1'b0; tick();
    chk("R6 lock kept", 1'b0, 1'b1);
    tx = 1'b0;
    expect_release("R6 release");

    // R7: low supply
    do_reset();
    sup = 1'b0; tick();
    chk("R7 low supply", 1'b0, 1'b1);
    tick();
    chk("R7 still low", 1'b0, 1'b1);
    sup = 1'b1; tick();
    chk("R7 restored", 1'b1, 1'b0);

    // R7: low supply during burst does not clear the count
    do_reset();
    tx = 1'b1; repeat (J - 2) tick();
    sup = 1'b0; tick();
    chk("R7 forced mid burst", 1'b0, 1'b1);
    sup = 1'b1; tick();
    chk("R1 trip after supply dip", 1'b0, 1'b1);
    tx = 1'b0;
    expect_release("R7 release");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule